// File: doc/BRIEF.md
# SPI Double-Buffered Data Path

This block is the data path of a serial peripheral port that works either as bus master or as slave. One shift register sends and receives a character of 1 to 16 bits, most significant bit first. A transmit holding register lets software queue the next character while the current one is still moving. When that character ends, the queued value is moved into the shift register at once, so the next character follows on the serial lines with no gap.

Each received character is placed right-justified in a receive holding register, and a receive flag is raised at the same time. Software can read the received value at two bus addresses. The normal address clears the receive flag. The inspection address returns the same value and leaves every flag alone, so a debugger can watch the data without disturbing the interrupt logic. If a second character arrives before software has taken the first, an overrun flag is raised. Software clears it by writing a one.

In master mode the block makes the serial clock itself, using a simple divider, and drives the active-low select line. In slave mode it follows a clock and select line supplied from outside, and synchronises them internally.

Top module: `spi_dbuf`

## Requirements
- R1: When a character completes, its value appears at both read addresses (2 and 3) and `irq_flag` is 1 on the following cycle.
- R2: A bus read at address 2 clears `irq_flag`, unless a character completes in the same cycle, in which case the flag stays set.
- R3: A bus read at address 3 returns the same value as address 2 and leaves `irq_flag` unchanged.
- R4: `cfg_len` = n selects n+1 bits. Transmit bits come from the top n+1 bits of the written 16-bit word, most significant first. The received character is stored right-justified with zeros above it.
- R5: A write at address 1 while a character is in progress sets `txfull_flag`.
- R6: When a character completes with `txfull_flag` set, the held word goes into the shift register and `txfull_flag` clears. In master mode the next character follows with `cs_n_o` held low throughout.
- R7: A write at address 1 while no character is in progress goes straight to the shift register, and `txfull_flag` stays 0.
- R8: In master mode, an idle write at address 0 or address 1 pulls `cs_n_o` low on the next cycle. `sclk_o` idles low, and each half period lasts `cfg_div`+1 clock cycles. MOSI changes on the falling edge and MISO is sampled on the rising edge.
- R9: A write at address 0 while a character is in progress is ignored.
- R10: A completion while `irq_flag` is set (and not being cleared) overwrites the receive value and sets `ovr_flag`. A write at address 2 with bit 0 = 1 clears `ovr_flag`; a write with bit 0 = 0 leaves it set.
- R11: After reset all flags and buffers read 0, `cs_n_o` is 1 and `sclk_o` is 0.
- R12: In slave mode the block samples `mosi_i` on rising edges of `sclk_i` while `cs_n_i` is low, drives `miso_o` from the shift register, and applies the same buffering and flag rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_len | input | 4 | Character length minus one |
| cfg_div | input | 8 | Half-period of the master clock, in clock cycles, minus one |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | 0 shift, 1 transmit hold, 2 receive (write: overrun clear), 3 receive inspection |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data: the receive value at addresses 2 and 3, otherwise 0 |
| irq_flag | output | 1 | Character received |
| txfull_flag | output | 1 | Transmit holding register occupied |
| ovr_flag | output | 1 | Receive overrun |
| sclk_o | output | 1 | Serial clock out (master) |
| cs_n_o | output | 1 | Select out, active low (master) |
| mosi_o | output | 1 | Serial data out (master) |
| miso_i | input | 1 | Serial data in (master) |
| sclk_i | input | 1 | Serial clock in (slave) |
| cs_n_i | input | 1 | Select in, active low (slave) |
| mosi_i | input | 1 | Serial data in (slave) |
| miso_o | output | 1 | Serial data out (slave) |

## Verification
The bench builds the block with its default parameters: 16-bit data and an 8-bit divider. With these, the 1-bit, 4-bit, 8-bit and full 16-bit character lengths can all be exercised. The divider is set to 1 at run time. This keeps each character to a few dozen cycles and makes the cycle count of one master character an exact check. A bench-side serial device gives back known words, so justification and bit order are checked in both directions. A hand-driven slave clock exercises the synchronised slave path, including a transmit hand-off in the middle of a character.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;
  typedef enum logic [1:0] {
    REG_SHIFT = 2'd0,
    REG_TXHLD = 2'd1,
    REG_RXBUF = 2'd2,
    REG_RXMIR = 2'd3
  } spi_reg_e;
endpackage

// File: rtl/spi_sclk_gen.sv
// Master: divider producing sclk and edge strobes. Slave: synchronised edges.
module spi_sclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  input  logic             sclk_i,
  input  logic             cs_n_i,
  output logic             rise,
  output logic             fall,
  output logic             sclk_o,
  output logic             sel
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             sclk_q, sclk_d;
  logic [2:0]       ssync_q;
  logic [1:0]       csync_q;
  logic             tick;

  assign tick = master && run && (cnt_q == div);

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!master || !run) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (tick) begin
      cnt_d  = '0;
      sclk_d = !sclk_q;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      sclk_q  <= 1'b0;
      ssync_q <= '0;
      csync_q <= 2'b11;
    end else begin
      cnt_q   <= cnt_d;
      sclk_q  <= sclk_d;
      ssync_q <= {ssync_q[1:0], sclk_i};
      csync_q <= {csync_q[0], cs_n_i};
    end
  end

  assign sel    = !csync_q[1];
  assign sclk_o = sclk_q;
  assign rise   = master ? (tick && !sclk_q) : (sel && ssync_q[1] && !ssync_q[2]);
  assign fall   = master ? (tick && sclk_q)  : (sel && !ssync_q[1] && ssync_q[2]);
endmodule

// File: rtl/spi_shift_core.sv
// Single shift register: MSB out, sampled bit in at LSB.
module spi_shift_core #(
  parameter int DATA_W = 16,
  localparam int LEN_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master,
  input  logic              sel,
  input  logic              rise,
  input  logic              fall,
  input  logic [LEN_W-1:0]  len,
  input  logic              in_bit,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_data,
  output logic              out_bit
);
  localparam logic [DATA_W-1:0] ONES = '1;
  localparam logic [LEN_W-1:0]  TOP  = LEN_W'(DATA_W - 1);

  logic [DATA_W-1:0] shreg_q, shreg_d, shifted;
  logic [LEN_W-1:0]  bcnt_q, bcnt_d;
  logic              samp_q, samp_d;
  logic              busy_q, busy_d;

  assign shifted = {shreg_q[DATA_W-2:0], samp_q};
  assign done    = busy_q && fall && (bcnt_q == len);
  assign rx_data = shifted & (ONES >> (TOP - len));

  always_comb begin
    shreg_d = shreg_q;
    bcnt_d  = bcnt_q;
    samp_d  = samp_q;
    busy_d  = busy_q;
    if (rise) samp_d = in_bit;
    if (!master && rise && !busy_q) begin
      busy_d = 1'b1;
      bcnt_d = '0;
    end
    if (fall && busy_q) begin
      shreg_d = shifted;
      if (done) begin
        bcnt_d = '0;
        busy_d = 1'b0;
      end else begin
        bcnt_d = bcnt_q + 1'b1;
      end
    end
    if (!master && !sel) begin
      busy_d = 1'b0;
      bcnt_d = '0;
    end
    if (load) begin
      shreg_d = load_data;
      bcnt_d  = '0;
      if (master) busy_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      bcnt_q  <= '0;
      samp_q  <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      shreg_q <= shreg_d;
      bcnt_q  <= bcnt_d;
      samp_q  <= samp_d;
      busy_q  <= busy_d;
    end
  end

  assign busy    = busy_q;
  assign out_bit = shreg_q[DATA_W-1];
endmodule

// File: rtl/spi_buf_ctl.sv
// Transmit holding register, receive register and flag rules.
module spi_buf_ctl
  import spi_dbuf_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              busy,
  input  logic              done,
  input  logic [DATA_W-1:0] rx_data,
  output logic              load,
  output logic [DATA_W-1:0] load_data,
  output logic [DATA_W-1:0] rx_buf,
  output logic              irq,
  output logic              txfull,
  output logic              ovr
);
  logic [DATA_W-1:0] txh_q, txh_d, rxb_q, rxb_d;
  logic              txf_q, txf_d, irq_q, irq_d, ovr_q, ovr_d;
  logic              wr_shift, wr_txh, rd_rx, wr_ovr;

  assign wr_shift = bus_wr && (bus_addr == REG_SHIFT);
  assign wr_txh   = bus_wr && (bus_addr == REG_TXHLD);
  assign rd_rx    = bus_rd && (bus_addr == REG_RXBUF);
  assign wr_ovr   = bus_wr && (bus_addr == REG_RXBUF) && bus_wdata[0];

  // transmit side
  always_comb begin
    load      = 1'b0;
    load_data = bus_wdata;
    txh_d     = txh_q;
    txf_d     = txf_q;
    if (done) begin
      if (txf_q) begin
        load      = 1'b1;
        load_data = txh_q;
        if (wr_txh) txh_d = bus_wdata;
        else        txf_d = 1'b0;
      end else if (wr_txh) begin
        load = 1'b1;
      end
    end else if (!busy) begin
      load = wr_shift || wr_txh;
    end else if (wr_txh) begin
      txh_d = bus_wdata;
      txf_d = 1'b1;
    end
  end

  // receive side
  always_comb begin
    rxb_d = done ? rx_data : rxb_q;
    irq_d = irq_q;
    ovr_d = ovr_q;
    if (done)       irq_d = 1'b1;
    else if (rd_rx) irq_d = 1'b0;
    if (done && irq_q && !rd_rx) ovr_d = 1'b1;
    else if (wr_ovr)             ovr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txh_q <= '0;
      txf_q <= 1'b0;
      rxb_q <= '0;
      irq_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      txh_q <= txh_d;
      txf_q <= txf_d;
      rxb_q <= rxb_d;
      irq_q <= irq_d;
      ovr_q <= ovr_d;
    end
  end

  assign rx_buf = rxb_q;
  assign irq    = irq_q;
  assign txfull = txf_q;
  assign ovr    = ovr_q;
endmodule

// File: rtl/spi_dbuf.sv
module spi_dbuf
  import spi_dbuf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8,
  localparam int LEN_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_master,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_flag,
  output logic              txfull_flag,
  output logic              ovr_flag,
  output logic              sclk_o,
  output logic              cs_n_o,
  output logic              mosi_o,
  input  logic              miso_i,
  input  logic              sclk_i,
  input  logic              cs_n_i,
  input  logic              mosi_i,
  output logic              miso_o
);
  logic              rise, fall, sel, core_busy, char_done, load, out_bit;
  logic [DATA_W-1:0] load_data, rx_data, rx_buf;

  spi_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
    .clk(clk), .rst_n(rst_n), .master(cfg_master), .run(core_busy),
    .div(cfg_div), .sclk_i(sclk_i), .cs_n_i(cs_n_i),
    .rise(rise), .fall(fall), .sclk_o(sclk_o), .sel(sel)
  );

  spi_shift_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n), .master(cfg_master), .sel(sel),
    .rise(rise), .fall(fall), .len(cfg_len),
    .in_bit(cfg_master ? miso_i : mosi_i),
    .load(load), .load_data(load_data),
    .busy(core_busy), .done(char_done), .rx_data(rx_data), .out_bit(out_bit)
  );

  spi_buf_ctl #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .busy(core_busy), .done(char_done), .rx_data(rx_data),
    .load(load), .load_data(load_data), .rx_buf(rx_buf),
    .irq(irq_flag), .txfull(txfull_flag), .ovr(ovr_flag)
  );

  assign bus_rdata = ((bus_addr == REG_RXBUF) || (bus_addr == REG_RXMIR)) ? rx_buf : '0;
  assign cs_n_o    = !(cfg_master && core_busy);
  assign mosi_o    = cfg_master && out_bit;
  assign miso_o    = !cfg_master && out_bit;
endmodule

// File: rtl/spi_dbuf_chk.sv
module spi_dbuf_chk
  import spi_dbuf_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_master,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [1:0] bus_addr,
  input logic       busy,
  input logic       done,
  input logic       irq_flag,
  input logic       txfull_flag,
  input logic       ovr_flag,
  input logic       cs_n_o,
  input logic       sclk_o
);
  logic wr_txh, rd_rx;
  assign wr_txh = bus_wr && (bus_addr == REG_TXHLD);
  assign rd_rx  = bus_rd && (bus_addr == REG_RXBUF);

  // R1
  irq_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> irq_flag);
  // R2
  rx_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && !done) |=> !irq_flag);
  // R3
  mirror_read_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == REG_RXMIR && irq_flag) |=> irq_flag);
  // R5
  txfull_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_txh && busy && !done) |=> txfull_flag);
  // R6
  reload_no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && done && txfull_flag && !wr_txh) |=> (!cs_n_o && !txfull_flag));
  // R7
  fall_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_txh && !busy && !txfull_flag) |=> !txfull_flag);
  // R8
  master_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && bus_wr && (bus_addr == REG_SHIFT || bus_addr == REG_TXHLD) && !busy)
      |=> !cs_n_o);
  // R10
  overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && irq_flag && !rd_rx) |=> ovr_flag);
  // R11
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sclk_o);
endmodule

bind spi_dbuf spi_dbuf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_addr(bus_addr), .busy(core_busy), .done(char_done),
  .irq_flag(irq_flag), .txfull_flag(txfull_flag), .ovr_flag(ovr_flag),
  .cs_n_o(cs_n_o), .sclk_o(sclk_o)
);

// File: tb/spi_dbuf_bench.sv
module spi_dbuf_bench;
  logic        clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, cfg_master, bus_wr, bus_rd;
  logic [3:0]  cfg_len;
  logic [7:0]  cfg_div;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        irq_flag, txfull_flag, ovr_flag, sclk_o, cs_n_o, mosi_o, miso_i;
  logic        sclk_i, cs_n_i, mosi_i, miso_o;

  int vectors = 0, miscompares = 0;
  bit finished = 0;
  int cur_len = 7;

  // serial device model used in master mode
  logic [15:0] m_tx [0:7];
  logic [15:0] m_rx [0:7];
  logic [15:0] m_acc;
  int m_rx_n, m_bit_in, m_tx_idx, m_tx_bit, m_cs_rise;
  logic [3:0] m_pos;

  assign cfg_len = 4'(cur_len);
  assign m_pos   = 4'(cur_len - m_tx_bit);
  assign miso_i  = m_tx[m_tx_idx[2:0]][m_pos];

  always @(posedge sclk_o) begin
    m_acc = {m_acc[14:0], mosi_o};
    m_bit_in++;
    if (m_bit_in == cur_len + 1) begin
      m_rx[m_rx_n[2:0]] = m_acc;
      m_rx_n++;
      m_bit_in = 0;
      m_acc = '0;
    end
  end
  always @(negedge sclk_o) begin
    m_tx_bit++;
    if (m_tx_bit > cur_len) begin
      m_tx_bit = 0;
      m_tx_idx++;
    end
  end
  always @(negedge cs_n_o) m_tx_bit = 0;
  always @(posedge cs_n_o) m_cs_rise++;

  spi_dbuf u_spi_dbuf (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_len(cfg_len),
    .cfg_div(cfg_div), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_flag(irq_flag),
    .txfull_flag(txfull_flag), .ovr_flag(ovr_flag), .sclk_o(sclk_o),
    .cs_n_o(cs_n_o), .mosi_o(mosi_o), .miso_i(miso_i), .sclk_i(sclk_i),
    .cs_n_i(cs_n_i), .mosi_i(mosi_i), .miso_o(miso_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_idle(output int lows, output int highs);
    lows = 0; highs = 0;
    for (int i = 0; i < 4000; i++) begin
      if (cs_n_o) break;
      lows++;
      if (sclk_o) highs++;
      @(negedge clk);
    end
  endtask

  task automatic model_reset();
    m_rx_n = 0; m_bit_in = 0; m_tx_idx = 0; m_tx_bit = 0; m_cs_rise = 0; m_acc = '0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R11 irq", irq_flag, 0);
    chk("R11 txfull", txfull_flag, 0);
    chk("R11 ovr", ovr_flag, 0);
    chk("R11 cs_n_o", cs_n_o, 1);
    chk("R11 sclk_o", sclk_o, 0);
    bus_read(2'd3, d);
    chk("R11 rx value", d, 16'h0);
  endtask

  task automatic t_master_basic();
    logic [15:0] d;
    int lo, hi;
    cfg_master = 1'b1; cur_len = 7; model_reset();
    m_tx[0] = 16'h003C;
    bus_write(2'd0, 16'hA500);
    chk("R8 cs low after start", cs_n_o, 0);
    wait_idle(lo, hi);
    chk("R8 cycles selected", lo, 32);
    chk("R8 cycles sclk high", hi, 16);
    chk("R4 mosi msb-first", m_rx[0], 16'h00A5);
    chk("R1 irq set", irq_flag, 1);
    bus_read(2'd3, d);
    chk("R3 mirror data", d, 16'h003C);
    chk("R3 irq kept", irq_flag, 1);
    bus_read(2'd2, d);
    chk("R1 rx data", d, 16'h003C);
    chk("R2 irq cleared", irq_flag, 0);
  endtask

  task automatic one_char(input int len, input logic [15:0] tx_word,
                          input logic [15:0] dev_word, input string tag);
    logic [15:0] d;
    int lo, hi;
    cur_len = len; model_reset();
    m_tx[0] = dev_word;
    bus_write(2'd0, tx_word << (15 - len));
    wait_idle(lo, hi);
    chk({tag, " mosi"}, m_rx[0], tx_word);
    bus_read(2'd2, d);
    chk({tag, " rx right-justified"}, d, dev_word);
  endtask

  task automatic t_lengths();
    cfg_master = 1'b1;
    one_char(15, 16'h5AF0, 16'hC3A5, "R4 len16");
    one_char(0,  16'h0001, 16'h0001, "R4 len1");
    one_char(0,  16'h0000, 16'h0000, "R4 len1 zero");
    one_char(3,  16'h000B, 16'h0006, "R4 len4");
  endtask

  task automatic t_fallthrough();
    logic [15:0] d;
    int lo, hi;
    cfg_master = 1'b1; cur_len = 7; model_reset();
    m_tx[0] = 16'h0081;
    bus_write(2'd1, 16'h9600);
    chk("R7 txfull stays 0", txfull_flag, 0);
    chk("R8 hold write starts", cs_n_o, 0);
    wait_idle(lo, hi);
    chk("R7 mosi", m_rx[0], 16'h0096);
    bus_read(2'd2, d);
    chk("R7 rx", d, 16'h0081);
  endtask

  task automatic t_buffered();
    logic [15:0] d;
    int lo, hi;
    cfg_master = 1'b1; cur_len = 7; model_reset();
    m_tx[0] = 16'h0011; m_tx[1] = 16'h0022;
    bus_write(2'd0, 16'h4400);
    bus_write(2'd1, 16'h7700);
    chk("R5 txfull set", txfull_flag, 1);
    wait_idle(lo, hi);
    chk("R6 txfull cleared", txfull_flag, 0);
    chk("R6 no deselect between", m_cs_rise, 1);
    chk("R6 chars sent", m_rx_n, 2);
    chk("R6 first word", m_rx[0], 16'h0044);
    chk("R6 second word", m_rx[1], 16'h0077);
    chk("R10 overrun set", ovr_flag, 1);
    bus_read(2'd3, d);
    chk("R10 overwritten", d, 16'h0022);
    bus_write(2'd2, 16'h0000);
    chk("R10 write 0 keeps", ovr_flag, 1);
    bus_write(2'd2, 16'h0001);
    chk("R10 write 1 clears", ovr_flag, 0);
    bus_read(2'd2, d);
  endtask

  task automatic t_ignore_shift_wr();
    logic [15:0] d;
    int lo, hi;
    cfg_master = 1'b1; cur_len = 7; model_reset();
    m_tx[0] = 16'h0000;
    bus_write(2'd0, 16'h1200);
    bus_write(2'd0, 16'hFF00);
    wait_idle(lo, hi);
    chk("R9 one char only", m_rx_n, 1);
    chk("R9 data unchanged", m_rx[0], 16'h0012);
    chk("R9 txfull untouched", txfull_flag, 0);
    bus_read(2'd2, d);
  endtask

  task automatic slave_bit(input logic din, output logic dout);
    mosi_i = din;
    repeat (6) @(negedge clk);
    dout = miso_o;
    sclk_i = 1'b1;
    repeat (6) @(negedge clk);
    sclk_i = 1'b0;
  endtask

  task automatic t_slave();
    logic [15:0] d;
    logic [7:0]  a = '0, b = '0;
    cfg_master = 1'b0; cur_len = 7;
    bus_write(2'd0, 16'hC500);
    chk("R12 master select idle", cs_n_o, 1);
    cs_n_i = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      slave_bit(1'(8'h5A >> i), a[i]);
      if (i == 5) bus_write(2'd1, 16'h3300);
    end
    repeat (6) @(negedge clk);
    chk("R12 miso word", a, 8'hC5);
    chk("R12 irq", irq_flag, 1);
    chk("R6 slave txfull cleared", txfull_flag, 0);
    bus_read(2'd2, d);
    chk("R12 rx", d, 16'h005A);
    for (int i = 7; i >= 0; i--) slave_bit(1'(8'h96 >> i), b[i]);
    repeat (6) @(negedge clk);
    cs_n_i = 1'b1;
    chk("R12 held word sent", b, 8'h33);
    bus_read(2'd2, d);
    chk("R12 second rx", d, 16'h0096);
    chk("R12 no overrun", ovr_flag, 0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_master = 1'b1; cfg_div = 8'd1;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
    sclk_i = 1'b0; cs_n_i = 1'b1; mosi_i = 1'b0;
    for (int i = 0; i < 8; i++) begin m_tx[i] = '0; m_rx[i] = '0; end
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_master_basic();
    t_lengths();
    t_fallthrough();
    t_buffered();
    t_ignore_shift_wr();
    t_slave();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule